// File: doc/BRIEF.md
# Pulse Edge Blanking Timer

This block sits between a gate or trigger input and the optical power-control loop of a pulsed laser driver. It cleans up the trigger, which has a selectable active level, a two-stage synchronizer and a persistence filter. It then decides whether each pulse may be accepted. For every accepted pulse it produces a gated laser enable and a blanking window after each edge, leading and trailing. It also produces an update window for the power loop, placed in the settled part of the pulse, and a single sample strobe at the end of that window.

A pulse whose rising edge comes sooner than a minimum period after the previous accepted rise is dropped whole, and a rate flag is raised. A pulse that ends before the update window completes gets no strobe and raises a short-pulse flag. The laser enable is passed only while the shutter-open confirmation and the supervisor permit are both present. Both are sampled each clock, so losing either turns the enable off at the next edge.

Top module: `pulse_window_gen`

## Requirements
- R1: With `trig_active_low` = 1 a low level on `trig_in` is a pulse and a high level is idle; with 0 the levels are reversed. Both settings give identical timing.
- R2: A change of the (polarity-corrected) trigger level is taken only after it has persisted for DEB_CYC consecutive synchronized samples; shorter excursions cause no output activity.
- R3: An accepted input pulse of N cycles gives `laser_en` high for exactly N cycles, starting 2+DEB_CYC clock edges after the first edge that samples the new level. Each cycle is gated by the `shutter_ok` and `permit` values sampled at the edge that sets it.
- R4: Whenever `permit` is sampled low, `laser_en` is low after that clock edge, whatever the window state.
- R5: `blank` is high during the first BLANK_CYC cycles of the enable window and during the BLANK_CYC cycles directly after that window ends.
- R6: `apc_hold` is low only during enable-window cycles k (k = 0 at the first window cycle) with BLANK_CYC <= k < BLANK_CYC+SAMPLE_CYC, and high otherwise, including during all blanking.
- R7: `sample_stb` is a single-cycle pulse at window cycle k = BLANK_CYC+SAMPLE_CYC-1, issued only when the pulse is still in its window there.
- R8: A pulse with N < BLANK_CYC+SAMPLE_CYC gives no strobe and a one-cycle `short_flag` in the cycle right after its enable window ends.
- R9: A rise that comes fewer than MIN_PERIOD cycles after the previous accepted rise is ignored, and so is its later fall. No enable, blanking or update window follows it, and `rate_flag` is high for one cycle where the window would have begun.
- R10: After reset, `laser_en`, `blank`, `sample_stb`, `short_flag` and `rate_flag` are low, `apc_hold` is high, and the first valid pulse is accepted without a period check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Raw gate/trigger input, asynchronous |
| trig_active_low | input | 1 | 1: low level on `trig_in` means pulse |
| shutter_ok | input | 1 | Shutter confirmed open |
| permit | input | 1 | Emission permit from the safety supervisor |
| laser_en | output | 1 | Gated laser enable |
| blank | output | 1 | Edge blanking window |
| apc_hold | output | 1 | Freeze power-loop updates when high |
| sample_stb | output | 1 | One-cycle sample strobe in the settled window |
| short_flag | output | 1 | One-cycle flag: pulse ended before the update window completed |
| rate_flag | output | 1 | One-cycle flag: rising edge rejected for period violation |

## Verification
The bench builds the block with DEB_CYC = 2, BLANK_CYC = 3, SAMPLE_CYC = 2 and MIN_PERIOD = 16. With these values the update window ends five cycles into the pulse, so a sweep of widths from 2 to 9 crosses the short-pulse boundary on both sides. Gaps of 8, 12 and 16 cycles place consecutive rises from 10 to 25 cycles apart, straddling the period limit. The bench checks every output in every cycle, under both trigger polarities. It also covers sub-debounce glitches, a shutter that is absent or drops during a pulse, and a permit that drops inside the window.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
    // Debounced edge events handed from the input conditioner to the timer core.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/pwg_debounce.sv
module pwg_debounce
    import pwg_pkg::*;
#(
    parameter int DEB_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     trig_in,
    input  logic     active_low,
    output edge_ev_t ev
);
    localparam int DW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   level;
        logic [DW-1:0]          cnt;
        edge_ev_t               ev;
    } deb_st_t;

    deb_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        // polarity applied before the synchronizer so a polarity change
        // together with an idle-level change never looks like an edge
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], trig_in ^ active_low};
        s_d.ev   = '0;
        if (s_q.sync[SYNC_STAGES-1] != s_q.level) begin
            if (s_q.cnt == DW'(DEB_CYC - 1)) begin
                s_d.level   = s_q.sync[SYNC_STAGES-1];
                s_d.cnt     = '0;
                s_d.ev.rise = s_q.sync[SYNC_STAGES-1];
                s_d.ev.fall = !s_q.sync[SYNC_STAGES-1];
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ev = s_q.ev;
endmodule

// File: rtl/pwg_window.sv
module pwg_window
    import pwg_pkg::*;
#(
    parameter int BLANK_CYC  = 16,
    parameter int SAMPLE_CYC = 8,
    parameter int MIN_PERIOD = 200
) (
    input  logic     clk,
    input  logic     rst_n,
    input  edge_ev_t ev,
    input  logic     shutter_ok,
    input  logic     permit,
    output logic     laser_en,
    output logic     blank,
    output logic     apc_hold,
    output logic     sample_stb,
    output logic     short_flag,
    output logic     rate_flag
);
    localparam int WIN_END = BLANK_CYC + SAMPLE_CYC;
    localparam int CW      = $clog2(WIN_END + 1);
    localparam int PW      = (MIN_PERIOD < 2) ? 1 : $clog2(MIN_PERIOD + 1);

    typedef struct packed {
        logic          active;
        logic          seen;
        logic [CW-1:0] wcnt;
        logic [CW-1:0] tcnt;
        logic [PW-1:0] pcnt;
        logic          las_en;
        logic          short_f;
        logic          rate_f;
    } win_st_t;

    win_st_t s_d, s_q;
    logic    period_ok;
    logic    in_window;

    assign period_ok = !s_q.seen || (s_q.pcnt == PW'(MIN_PERIOD - 1));

    always_comb begin
        s_d         = s_q;
        s_d.short_f = 1'b0;
        s_d.rate_f  = 1'b0;
        if (s_q.pcnt != PW'(MIN_PERIOD - 1)) s_d.pcnt = s_q.pcnt + 1'b1;
        if (s_q.active && (s_q.wcnt != CW'(WIN_END))) s_d.wcnt = s_q.wcnt + 1'b1;
        if (s_q.tcnt != '0) s_d.tcnt = s_q.tcnt - 1'b1;

        if (ev.rise) begin
            if (period_ok) begin
                s_d.active = 1'b1;
                s_d.seen   = 1'b1;
                s_d.wcnt   = '0;
                s_d.tcnt   = '0;
                s_d.pcnt   = '0;
            end else begin
                s_d.rate_f = 1'b1;
            end
        end
        if (ev.fall && s_q.active) begin
            s_d.active  = 1'b0;
            s_d.tcnt    = CW'(BLANK_CYC);
            s_d.short_f = (s_q.wcnt < CW'(WIN_END - 1));
        end
        s_d.las_en = s_d.active && shutter_ok && permit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_window  = s_q.active && (s_q.wcnt >= CW'(BLANK_CYC)) && (s_q.wcnt < CW'(WIN_END));
    assign laser_en   = s_q.las_en;
    assign blank      = (s_q.active && (s_q.wcnt < CW'(BLANK_CYC))) || (s_q.tcnt != '0);
    assign apc_hold   = !in_window;
    assign sample_stb = s_q.active && (s_q.wcnt == CW'(WIN_END - 1));
    assign short_flag = s_q.short_f;
    assign rate_flag  = s_q.rate_f;
endmodule

// File: rtl/pulse_window_gen.sv
module pulse_window_gen
    import pwg_pkg::*;
#(
    parameter int DEB_CYC    = 4,
    parameter int BLANK_CYC  = 16,
    parameter int SAMPLE_CYC = 8,
    parameter int MIN_PERIOD = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic trig_active_low,
    input  logic shutter_ok,
    input  logic permit,
    output logic laser_en,
    output logic blank,
    output logic apc_hold,
    output logic sample_stb,
    output logic short_flag,
    output logic rate_flag
);
    edge_ev_t ev;

    pwg_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (trig_in),
        .active_low (trig_active_low),
        .ev         (ev)
    );

    pwg_window #(
        .BLANK_CYC  (BLANK_CYC),
        .SAMPLE_CYC (SAMPLE_CYC),
        .MIN_PERIOD (MIN_PERIOD)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .shutter_ok (shutter_ok),
        .permit     (permit),
        .laser_en   (laser_en),
        .blank      (blank),
        .apc_hold   (apc_hold),
        .sample_stb (sample_stb),
        .short_flag (short_flag),
        .rate_flag  (rate_flag)
    );
endmodule

// File: rtl/pwg_checker.sv
module pwg_checker (
    input logic clk,
    input logic rst_n,
    input logic shutter_ok,
    input logic permit,
    input logic laser_en,
    input logic blank,
    input logic apc_hold,
    input logic sample_stb,
    input logic short_flag,
    input logic rate_flag
);
    p_permit_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !permit |=> !laser_en);

    p_shutter_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !shutter_ok |=> !laser_en);

    p_blank_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> apc_hold);

    p_stb_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (!blank && !apc_hold));

    p_stb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    p_short_no_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        short_flag |-> (!laser_en && !sample_stb));

    p_rate_no_emit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rate_flag |-> !laser_en);
endmodule

bind pulse_window_gen pwg_checker u_pwg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shutter_ok (shutter_ok),
    .permit     (permit),
    .laser_en   (laser_en),
    .blank      (blank),
    .apc_hold   (apc_hold),
    .sample_stb (sample_stb),
    .short_flag (short_flag),
    .rate_flag  (rate_flag)
);

// File: tb/pulse_window_gen_bench.sv
module pulse_window_gen_bench;
    localparam int DEB   = 2;
    localparam int BL    = 3;
    localparam int SM    = 2;
    localparam int MINP  = 16;
    localparam int LAT   = 2 + DEB;
    localparam int WE    = BL + SM;
    localparam int NEVER = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_in = 1'b0;
    logic trig_active_low = 1'b0;
    logic shutter_ok = 1'b1;
    logic permit = 1'b1;
    logic laser_en, blank, apc_hold, sample_stb, short_flag, rate_flag;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_rise = 0;
    bit have_prev = 1'b0;
    bit pol = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pulse_window_gen #(
        .DEB_CYC(DEB), .BLANK_CYC(BL), .SAMPLE_CYC(SM), .MIN_PERIOD(MINP)
    ) u_pulse_window_gen (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_active_low(trig_active_low),
        .shutter_ok(shutter_ok), .permit(permit), .laser_en(laser_en), .blank(blank),
        .apc_hold(apc_hold), .sample_stb(sample_stb), .short_flag(short_flag),
        .rate_flag(rate_flag)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cyc, act, exp);
        end
    endtask

    // n cycles active, then g idle; shutter low from cycle sh_drop, permit low from pm_drop
    task automatic pulse(input int n, input int g, input int sh_drop, input int pm_drop);
        bit acc;
        string en_tag;
        acc = !have_prev || ((cyc - last_rise) >= MINP);
        if (acc) begin
            last_rise = cyc;
            have_prev = 1'b1;
        end
        en_tag = (pm_drop < NEVER) ? "R4" : (pol ? "R1" : "R3");
        for (int c = 0; c < n + g; c++) begin
            int  k;
            bit  act, e_en, e_blank, e_win, e_stb, e_short, e_rate;
            @(negedge clk);
            k       = c - 1 - LAT;
            act     = acc && (k >= 0) && (k < n);
            e_en    = act && shutter_ok && permit;
            e_blank = acc && (((k >= 0) && (k < BL) && (k < n)) || ((k >= n) && (k < n + BL)));
            e_win   = act && (k >= BL) && (k < WE);
            e_stb   = act && (k == WE - 1);
            e_short = acc && (k == n) && (n < WE);
            e_rate  = !acc && (k == 0);
            chk(en_tag, "laser_en", laser_en, e_en);
            chk("R5", "blank", blank, e_blank);
            chk("R6", "apc_hold", apc_hold, !e_win);
            chk("R7", "sample_stb", sample_stb, e_stb);
            chk("R8", "short_flag", short_flag, e_short);
            chk("R9", "rate_flag", rate_flag, e_rate);
            trig_in    = pol ^ (c < n);
            shutter_ok = (c < sh_drop);
            permit     = (c < pm_drop);
            cyc++;
        end
    endtask

    // excursion shorter than the debounce length: nothing may react (R2)
    task automatic glitch(input int w, input int g);
        for (int c = 0; c < w + g; c++) begin
            @(negedge clk);
            chk("R2", "laser_en", laser_en, 1'b0);
            chk("R2", "blank", blank, 1'b0);
            chk("R2", "apc_hold", apc_hold, 1'b1);
            chk("R2", "sample_stb", sample_stb, 1'b0);
            chk("R2", "rate_flag", rate_flag, 1'b0);
            trig_in    = pol ^ (c < w);
            shutter_ok = 1'b1;
            permit     = 1'b1;
            cyc++;
        end
    endtask

    task automatic set_pol(input bit p);
        @(negedge clk);
        pol = p;
        trig_active_low = p;
        trig_in = p;
        cyc++;
        repeat (6) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "laser_en", laser_en, 1'b0);
        chk("R10", "blank", blank, 1'b0);
        chk("R10", "apc_hold", apc_hold, 1'b1);
        chk("R10", "sample_stb", sample_stb, 1'b0);
        chk("R10", "short_flag", short_flag, 1'b0);
        chk("R10", "rate_flag", rate_flag, 1'b0);
        cyc++;

        for (int p = 0; p < 2; p++) begin
            set_pol(p[0]);
            glitch(1, 12);
            for (int n = 2; n <= 9; n++) begin
                for (int gi = 0; gi < 3; gi++) begin
                    pulse(n, 8 + 4 * gi, NEVER, NEVER);
                end
            end
            // shutter absent for a whole pulse, then dropping mid-pulse (R3)
            pulse(8, 20, 0, NEVER);
            pulse(8, 20, LAT + 4, NEVER);
            // permit dropping inside the window (R4)
            pulse(9, 20, NEVER, LAT + 3);
            pulse(7, 20, NEVER, LAT + 6);
            glitch(1, 12);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule